// File: doc/BRIEF.md
# SDRAM Low-Power Mode Sequencer

This block sits between an SDRAM controller and the memory. It owns the clock-enable pin and the four command strobes (chip select, row strobe, column strobe, write enable). It moves the memory between normal operation, two power-down flavours and self refresh. The surrounding controller asks for sleep or self refresh through request inputs and later asks to wake. It also reports whether any bank still has an open row.

While `ready_o` is high, the controller owns the command bus and drives its own commands. This block's command outputs stay at NOP then, and an external multiplexer selects the controller. While `ready_o` is low, this block's command outputs are the ones that reach the memory.

On the way in and out, the block enforces the minimum cycle counts: precharge recovery before self refresh, exit recovery after power-down and exit recovery after self refresh. It also limits how long the memory may stay in power-down, so that the controller regains the bus in time to issue a refresh. Every timing is a parameter given in clock cycles.

Top module: `sdram_lp_seq`

## Requirements
- R1: After reset, clock-enable is high, the command pins carry NOP (`{cs_n,ras_n,cas_n,we_n}` = 0111), `ready_o` is 1, `pd_mode_o` is 00, and `ack_o` and `refresh_due_o` are 0.
- R2: A sleep request accepted in the normal state while `bank_open_i` is 0 lowers clock-enable at the next clock edge, with NOP on the command pins, and sets `pd_mode_o` to 01 (precharge power-down). `ready_o` falls at that same edge.
- R3: A sleep request accepted while `bank_open_i` is 1 enters power-down in the same way, with `pd_mode_o` set to 10 (active power-down).
- R4: While in either power-down mode, the command pins carry NOP on every cycle.
- R5: A wake request in power-down raises clock-enable at the next edge, with NOP on the command pins. `ready_o` returns exactly `T_PDEX` cycles after clock-enable rises.
- R6: Without a wake request, clock-enable stays low in power-down for exactly `T_PDMAX` cycles, and then the block leaves power-down as in R5. `refresh_due_o` is high from that forced exit up to and including the first cycle in which `ready_o` is high again, and it is low on the cycle after.
- R7: A self-refresh request accepted with `bank_open_i` at 0 drives the refresh command (0001) with clock-enable low at the next edge and sets `pd_mode_o` to 11. Every later cycle of self refresh drives deselect (`cs_n` = 1) with clock-enable low.
- R8: A self-refresh request accepted with `bank_open_i` at 1 first drives precharge-all (0010 with `a10_o` = 1) while clock-enable stays high. NOP follows, and the refresh command of R7 comes exactly `T_RP` cycles after the precharge. `a10_o` is high only with precharge.
- R9: A wake request in self refresh drives NOP with clock-enable high at the next edge. NOP stays on the pins, and `ready_o` returns exactly `T_XSR` cycles after clock-enable rises.
- R10: When self-refresh and sleep requests arrive together in the normal state, self refresh wins. A wake request in the normal state, and sleep or self-refresh requests outside it, have no effect.
- R11: `ack_o` is a one-cycle pulse in the cycle after each accepted request. A forced exit (R6) gives no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_sleep_i | input | 1 | Request power-down |
| req_selfref_i | input | 1 | Request self refresh |
| req_wake_i | input | 1 | Request return to normal operation |
| bank_open_i | input | 1 | Any bank has an open row |
| ack_o | output | 1 | One-cycle acknowledge of an accepted request |
| ready_o | output | 1 | Controller may issue normal commands |
| refresh_due_o | output | 1 | Power-down was ended by the duration limit |
| pd_mode_o | output | 2 | 00 normal, 01 precharge PD, 10 active PD, 11 self refresh |
| cke_o | output | 1 | Memory clock-enable |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| a10_o | output | 1 | Address bit 10, high for precharge-all |

## Verification
Each accepted request shows on the registered pins and on `ack_o` one edge after it is sampled. The bench drives requests on a falling edge and checks the response on the next falling edge. The delayed results fall due exactly `T_PDEX`, `T_XSR`, `T_RP` or `T_PDMAX` cycles after their trigger edge. The bench counts falling edges from that edge until the expected event and compares the count with the parameter. In this way an early result and a late result are both caught.

// File: rtl/sdram_lp_pkg.sv
package sdram_lp_pkg;

  typedef struct packed {
    logic cs_n;
    logic ras_n;
    logic cas_n;
    logic we_n;
  } sd_cmd_t;

  localparam sd_cmd_t CMD_NOP   = 4'b0111;
  localparam sd_cmd_t CMD_DESEL = 4'b1111;
  localparam sd_cmd_t CMD_PRE   = 4'b0010;
  localparam sd_cmd_t CMD_REF   = 4'b0001;

  typedef enum logic [2:0] {
    ST_NORM,
    ST_PD,
    ST_PD_EXIT,
    ST_PRE_WAIT,
    ST_SR,
    ST_SR_EXIT
  } lp_state_t;

  typedef enum logic [1:0] {
    MODE_NONE = 2'b00,
    MODE_PPD  = 2'b01,
    MODE_APD  = 2'b10,
    MODE_SR   = 2'b11
  } lp_mode_t;

  localparam int TMR_RP    = 0;
  localparam int TMR_PDEX  = 1;
  localparam int TMR_XSR   = 2;
  localparam int TMR_PDMAX = 3;
  localparam int N_TMR     = 4;

endpackage

// File: rtl/sdram_lp_timer.sv
module sdram_lp_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (load_i)          cnt_q <= val_i;
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/sdram_lp_cmd_reg.sv
module sdram_lp_cmd_reg
  import sdram_lp_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  sd_cmd_t cmd_d,
  input  logic    cke_d,
  input  logic    a10_d,
  output sd_cmd_t cmd_q,
  output logic    cke_q,
  output logic    a10_q
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q <= CMD_NOP;
      cke_q <= 1'b1;
      a10_q <= 1'b0;
    end else begin
      cmd_q <= cmd_d;
      cke_q <= cke_d;
      a10_q <= a10_d;
    end
  end
endmodule

// File: rtl/sdram_lp_seq.sv
module sdram_lp_seq
  import sdram_lp_pkg::*;
#(
  parameter int T_RP    = 3,
  parameter int T_PDEX  = 2,
  parameter int T_XSR   = 10,
  parameter int T_PDMAX = 50
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_sleep_i,
  input  logic       req_selfref_i,
  input  logic       req_wake_i,
  input  logic       bank_open_i,
  output logic       ack_o,
  output logic       ready_o,
  output logic       refresh_due_o,
  output logic [1:0] pd_mode_o,
  output logic       cke_o,
  output logic       cs_n_o,
  output logic       ras_n_o,
  output logic       cas_n_o,
  output logic       we_n_o,
  output logic       a10_o
);

  localparam int T_MAX_A = (T_RP > T_PDEX) ? T_RP : T_PDEX;
  localparam int T_MAX_B = (T_XSR > T_PDMAX) ? T_XSR : T_PDMAX;
  localparam int T_MAX   = (T_MAX_A > T_MAX_B) ? T_MAX_A : T_MAX_B;
  localparam int TW      = $clog2(T_MAX + 1);

  initial begin
    if (T_RP < 1 || T_PDEX < 1 || T_XSR < 1 || T_PDMAX < 1)
      $error("timing parameters must be at least 1");
  end

  function automatic int tmr_cycles(int idx);
    case (idx)
      TMR_RP:   return T_RP;
      TMR_PDEX: return T_PDEX;
      TMR_XSR:  return T_XSR;
      default:  return T_PDMAX;
    endcase
  endfunction

  lp_state_t       state_q, state_d;
  logic            apd_q, apd_d;
  logic            ack_q, due_q;
  logic [N_TMR-1:0] tmr_load, tmr_done;
  logic            accept, forced;
  sd_cmd_t         cmd_d, cmd_q;
  logic            cke_d, a10_d;

  // one down-counter per timing
  for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
    localparam logic [TW-1:0] LOAD_VAL = TW'(tmr_cycles(g) - 1);
    sdram_lp_timer #(.W(TW)) u_tmr (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (tmr_load[g]),
      .val_i  (LOAD_VAL),
      .done_o (tmr_done[g])
    );
  end

  always_comb begin
    state_d  = state_q;
    apd_d    = apd_q;
    cmd_d    = CMD_NOP;
    cke_d    = 1'b1;
    a10_d    = 1'b0;
    tmr_load = '0;
    accept   = 1'b0;
    forced   = 1'b0;
    unique case (state_q)
      ST_NORM: begin
        if (req_selfref_i) begin
          accept = 1'b1;
          if (bank_open_i) begin
            state_d          = ST_PRE_WAIT;
            cmd_d            = CMD_PRE;
            a10_d            = 1'b1;
            tmr_load[TMR_RP] = 1'b1;
          end else begin
            state_d = ST_SR;
            cmd_d   = CMD_REF;
            cke_d   = 1'b0;
          end
        end else if (req_sleep_i) begin
          accept              = 1'b1;
          state_d             = ST_PD;
          cke_d               = 1'b0;
          apd_d               = bank_open_i;
          tmr_load[TMR_PDMAX] = 1'b1;
        end
      end
      ST_PD: begin
        cke_d = 1'b0;
        if (req_wake_i || tmr_done[TMR_PDMAX]) begin
          accept             = req_wake_i;
          forced             = !req_wake_i;
          state_d            = ST_PD_EXIT;
          cke_d              = 1'b1;
          tmr_load[TMR_PDEX] = 1'b1;
        end
      end
      ST_PD_EXIT: begin
        if (tmr_done[TMR_PDEX]) state_d = ST_NORM;
      end
      ST_PRE_WAIT: begin
        if (tmr_done[TMR_RP]) begin
          state_d = ST_SR;
          cmd_d   = CMD_REF;
          cke_d   = 1'b0;
        end
      end
      ST_SR: begin
        cke_d = 1'b0;
        cmd_d = CMD_DESEL;
        if (req_wake_i) begin
          accept            = 1'b1;
          state_d           = ST_SR_EXIT;
          cke_d             = 1'b1;
          cmd_d             = CMD_NOP;
          tmr_load[TMR_XSR] = 1'b1;
        end
      end
      ST_SR_EXIT: begin
        if (tmr_done[TMR_XSR]) state_d = ST_NORM;
      end
      default: state_d = ST_NORM;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_NORM;
      apd_q   <= 1'b0;
      ack_q   <= 1'b0;
      due_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      apd_q   <= apd_d;
      ack_q   <= accept;
      if (forced)                 due_q <= 1'b1;
      else if (state_q == ST_NORM) due_q <= 1'b0;
    end
  end

  sdram_lp_cmd_reg u_cmd (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cmd_d  (cmd_d),
    .cke_d  (cke_d),
    .a10_d  (a10_d),
    .cmd_q  (cmd_q),
    .cke_q  (cke_o),
    .a10_q  (a10_o)
  );

  always_comb begin
    unique case (state_q)
      ST_PD:   pd_mode_o = apd_q ? MODE_APD : MODE_PPD;
      ST_SR:   pd_mode_o = MODE_SR;
      default: pd_mode_o = MODE_NONE;
    endcase
  end

  assign ready_o       = (state_q == ST_NORM);
  assign ack_o         = ack_q;
  assign refresh_due_o = due_q;
  assign cs_n_o        = cmd_q.cs_n;
  assign ras_n_o       = cmd_q.ras_n;
  assign cas_n_o       = cmd_q.cas_n;
  assign we_n_o        = cmd_q.we_n;

endmodule

// File: rtl/sdram_lp_seq_chk.sv
module sdram_lp_seq_chk #(
  parameter int T_PDMAX = 50
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ack_o,
  input logic       ready_o,
  input logic [1:0] pd_mode_o,
  input logic       cke_o,
  input logic       cs_n_o,
  input logic       ras_n_o,
  input logic       cas_n_o,
  input logic       we_n_o,
  input logic       a10_o
);
  localparam int CW = $clog2(T_PDMAX + 2);

  logic [3:0]    cmd;
  logic          pd_low;
  logic [CW-1:0] low_cnt;

  assign cmd    = {cs_n_o, ras_n_o, cas_n_o, we_n_o};
  assign pd_low = !cke_o && (pd_mode_o == 2'b01 || pd_mode_o == 2'b10);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     low_cnt <= '0;
    else if (pd_low) low_cnt <= low_cnt + 1'b1;
    else             low_cnt <= '0;
  end

  // R4
  pd_nop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_low |-> cmd == 4'b0111);

  // R7
  sr_desel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pd_mode_o == 2'b11 && $past(pd_mode_o) == 2'b11) |-> (cs_n_o && !cke_o));

  // R6
  pd_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pd_low |-> low_cnt < CW'(T_PDMAX));

  // R11
  ack_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_o |=> !ack_o);

  // R8
  a10_pre_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    a10_o |-> cmd == 4'b0010);

  // R5
  cke_rise_nop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cke_o) |-> cmd == 4'b0111);

  // R1
  ready_cke_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |-> (cke_o && pd_mode_o == 2'b00));
endmodule

bind sdram_lp_seq sdram_lp_seq_chk #(.T_PDMAX(T_PDMAX)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ack_o     (ack_o),
  .ready_o   (ready_o),
  .pd_mode_o (pd_mode_o),
  .cke_o     (cke_o),
  .cs_n_o    (cs_n_o),
  .ras_n_o   (ras_n_o),
  .cas_n_o   (cas_n_o),
  .we_n_o    (we_n_o),
  .a10_o     (a10_o)
);

// File: tb/sdram_lp_seq_bench.sv
module sdram_lp_seq_bench;
  localparam int T_RP = 3, T_PDEX = 2, T_XSR = 10, T_PDMAX = 50;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic req_sleep = 0, req_selfref = 0, req_wake = 0, bank_open = 0;
  logic ack, ready, due, cke, cs_n, ras_n, cas_n, we_n, a10;
  logic [1:0] mode;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  sdram_lp_seq #(.T_RP(T_RP), .T_PDEX(T_PDEX), .T_XSR(T_XSR), .T_PDMAX(T_PDMAX)) u_sdram_lp_seq (
    .clk_i(clk), .rst_ni(rst_ni), .req_sleep_i(req_sleep), .req_selfref_i(req_selfref),
    .req_wake_i(req_wake), .bank_open_i(bank_open), .ack_o(ack), .ready_o(ready),
    .refresh_due_o(due), .pd_mode_o(mode), .cke_o(cke), .cs_n_o(cs_n), .ras_n_o(ras_n),
    .cas_n_o(cas_n), .we_n_o(we_n), .a10_o(a10)
  );

  wire [3:0] cmd = {cs_n, ras_n, cas_n, we_n};

  // {sleep, selfref, bank_open, exp_cke, exp_cmd[3:0], exp_mode[1:0]}
  localparam logic [9:0] VEC [5] = '{
    10'b100_0_0111_01,   // R2
    10'b101_0_0111_10,   // R3
    10'b010_0_0001_11,   // R7
    10'b110_0_0001_11,   // R10 selfref wins
    10'b011_1_0010_00    // R8 precharge first
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic count_ready(output int n);
    n = 0;
    while (!ready && n < 1000) begin @(negedge clk); n++; end
  endtask

  task automatic go_home();
    int n;
    n = 0;
    while (mode == 2'b00 && n < 100) begin @(negedge clk); n++; end
    req_wake = 1; @(negedge clk); req_wake = 0;
    count_ready(n);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int n;
    logic bad;
    repeat (3) @(negedge clk);
    // R1
    chk("R1 cke", cke, 1); chk("R1 cmd", cmd, 4'b0111); chk("R1 ready", ready, 1);
    chk("R1 mode", mode, 0); chk("R1 ack", ack, 0); chk("R1 due", due, 0);
    rst_ni = 1; @(negedge clk);

    foreach (VEC[i]) begin
      req_sleep = VEC[i][9]; req_selfref = VEC[i][8]; bank_open = VEC[i][7];
      @(negedge clk);
      req_sleep = 0; req_selfref = 0; bank_open = 0;
      chk("R2/R3/R7/R8/R10 vec cke", cke, VEC[i][6]);
      chk("R2/R3/R7/R8/R10 vec cmd", cmd, VEC[i][5:2]);
      chk("R2/R3/R7/R8/R10 vec mode", mode, VEC[i][1:0]);
      chk("R11 vec ack", ack, 1);
      chk("R2 vec ready", ready, 0);
      @(negedge clk);
      chk("R11 ack one cycle", ack, 0);
      go_home();
      chk("vec return ready", ready, 1);
    end

    // R5 wake timing from power-down
    req_sleep = 1; @(negedge clk); req_sleep = 0;
    @(negedge clk); @(negedge clk);
    req_wake = 1; @(negedge clk); req_wake = 0;
    chk("R5 cke up", cke, 1); chk("R5 nop", cmd, 4'b0111); chk("R11 wake ack", ack, 1);
    count_ready(n);
    chk("R5 cycles to ready", n, T_PDEX);

    // R10 wake in normal ignored
    req_wake = 1; @(negedge clk); req_wake = 0;
    chk("R10 wake ignored ack", ack, 0); chk("R10 wake ignored ready", ready, 1);
    chk("R10 wake ignored cke", cke, 1);

    // R8 precharge to refresh spacing
    bank_open = 1; req_selfref = 1; @(negedge clk); req_selfref = 0; bank_open = 0;
    chk("R8 pre cmd", cmd, 4'b0010); chk("R8 a10", a10, 1); chk("R8 cke high", cke, 1);
    n = 0;
    while (cmd != 4'b0001 && n < 100) begin
      @(negedge clk); n++;
      if (cmd != 4'b0001) begin chk("R8 nop between", cmd, 4'b0111); chk("R8 a10 low", a10, 0); end
    end
    chk("R8 ref spacing", n, T_RP); chk("R7 ref cke low", cke, 0); chk("R7 sr mode", mode, 3);
    @(negedge clk);
    chk("R7 deselect", cs_n, 1); chk("R7 cke low", cke, 0);
    // R10 sleep/selfref ignored in self refresh
    req_sleep = 1; req_selfref = 1; @(negedge clk); req_sleep = 0; req_selfref = 0;
    chk("R10 ignored in sr ack", ack, 0); chk("R10 ignored in sr mode", mode, 3);
    // R9 exit
    req_wake = 1; @(negedge clk); req_wake = 0;
    chk("R9 cke up", cke, 1); chk("R9 nop", cmd, 4'b0111);
    n = 0; bad = 0;
    while (!ready && n < 1000) begin
      @(negedge clk); n++;
      if (cmd != 4'b0111 || !cke) bad = 1;
    end
    chk("R9 cycles to ready", n, T_XSR); chk("R9 nop during exit", bad, 0);

    // R6 forced exit
    req_sleep = 1; @(negedge clk); req_sleep = 0;
    chk("R10 ignored in pd pre", mode, 1);
    @(negedge clk);
    req_selfref = 1; @(negedge clk); req_selfref = 0;
    chk("R10 selfref ignored in pd ack", ack, 0); chk("R10 selfref ignored in pd mode", mode, 1);
    n = 3; bad = 0;
    while (!cke && n < 1000) begin
      if (cmd != 4'b0111) bad = 1;
      @(negedge clk);
      if (!cke) n++;
    end
    chk("R6 low cycles", n, T_PDMAX); chk("R4 nop in pd", bad, 0);
    chk("R6 due set", due, 1); chk("R11 no ack on forced", ack, 0);
    count_ready(n);
    chk("R6 exit spacing", n, T_PDEX); chk("R6 due at ready", due, 1);
    @(negedge clk);
    chk("R6 due cleared", due, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule